// File: doc/BRIEF.md
# Limit Timer

This block is a periodic counter-timer for a register-mapped peripheral space. An up-counter advances by one unit on every cycle where the tick-enable input is high. The count is shown in bits 30:9 of a 32-bit word, so one unit is 0x200 and the nine low bits always read as zero. When the next count would reach the programmed limit, the counter returns to zero. On that same tick a sticky flag is set and a level interrupt is raised. Counting then carries on, so the timer fires once every limit-period.

Software talks to the block through a single-cycle read/write port with a byte address; bits 4:2 of that address pick the word. One word writes the limit and restarts the count. Reading the same word returns the limit and acknowledges the event. A second word shows the count with the flag in its top bit. A third word changes the limit without disturbing the count. In a system the tick-enable input comes from a fixed 500 ns time base.

Top module: `limit_timer`

## Requirements
- R1: After a synchronous active-low reset, word 0 reads 0x7FFFFE00, word 1 reads 0x00000000, the timer is counting and `irq` is low.
- R2: On each clock with `tick_en` high, the count in word 1 rises by 0x200 and bits 8:0 stay zero; with `tick_en` low the count holds.
- R3: On a tick where the count plus one unit is at or above the limit, the count becomes zero, bit 31 of word 1 (reached) becomes 1 and `irq` goes high, all at that clock edge.
- R4: A write to word 0 (addr[4:2]=0) loads the limit from wdata & 0x7FFFFE00, forces the count to zero and drops `irq`; a tick in the same cycle is ignored and the reached flag is left as it was.
- R5: A write to word 0 or word 2 whose masked value is zero loads the limit 0x7FFFFE00.
- R6: A write to word 2 (addr[4:2]=2) loads the limit with the same masking but keeps the count, and a tick in the same cycle still counts against the old limit.
- R7: Reading word 0 returns the limit in bits 30:0 with bit 31 zero, and clears the reached flag and `irq` at that edge; if a reach event happens in the same cycle, the flag and `irq` stay set.
- R8: Reading word 1 (addr[4:2]=1) returns {reached, count[30:9], 9'b0} and changes no state.
- R9: Reads of words 3 to 7 return zero, and writes to words 1 and 3 to 7 change neither the limit nor the count.
- R10: If the limit is lowered to or below the current count, the next tick wraps the count to zero and raises the reached flag and `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One count step in this cycle |
| wr_en | input | 1 | Write strobe, single cycle |
| rd_en | input | 1 | Read strobe; read side effects take effect at the edge |
| addr | input | 5 | Byte address; bits 4:2 select the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The hardest cases to reach are the ones where several actions land on the same edge. One is an acknowledging read of word 0 in the exact cycle the count wraps. Another is a restart or a non-resetting limit write that meets a tick in the same cycle. The third is a limit lowered under a count that is already running. Directed sequences use small limits of a few units and place the tick, the read and the write on chosen cycles. A long random phase then mixes ticks, reads and writes to all eight words, with limits between zero and seven units. A behavioural model predicts `rdata` and `irq` on every clock.

// File: rtl/tmr_pkg.sv
// Package: shared types for the limit timer.
// Assumes a word-select field of three bits (byte address bits 4:2).
package tmr_pkg;

    // Word numbers seen through address bits 4:2
    typedef enum logic [2:0] {
        W_LIMRST  = 3'd0,
        W_COUNT   = 3'd1,
        W_LIMKEEP = 3'd2
    } word_e;

    // Decoded per-cycle control strobes
    typedef struct packed {
        logic restart;   // word 0 write: reload limit and zero the count
        logic lim_wr;    // word 0 or word 2 write: load limit
        logic ack_rd;    // word 0 read: clear reached and irq
    } ctl_t;

endpackage

// File: rtl/tmr_decode.sv
// Module: tmr_decode
// Turns the read/write strobes and word address into control strobes.
// Assumes the strobes are single-cycle and that the address is stable with them.
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int WORD_W = 3
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] word,
    output ctl_t              ctl
);

    // Combinational strobe decode
    always_comb begin
        ctl.restart = wr_en && (word == WORD_W'(W_LIMRST));
        ctl.lim_wr  = wr_en && ((word == WORD_W'(W_LIMRST)) ||
                                (word == WORD_W'(W_LIMKEEP)));
        ctl.ack_rd  = rd_en && (word == WORD_W'(W_LIMRST));
    end

endmodule

// File: rtl/tmr_limit.sv
// Module: tmr_limit
// Holds the limit in count units. A zero write is replaced by all ones.
// Assumes the caller has already shifted out the always-zero low bits.
module tmr_limit #(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wfield,
    output logic [CNT_W-1:0] lim
);

    // Limit register with the zero-means-maximum rule
    always_ff @(posedge clk) begin
        if (!rst_n)
            lim <= '1;
        else if (wr)
            lim <= (wfield == '0) ? '1 : wfield;
    end

    // R5: a zero write lands as the maximum limit
    a_r5_zero_is_max: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wfield == '0) |=> (lim == '1));

    // R4/R6: a nonzero write is taken verbatim
    a_r6_limit_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wfield != '0) |=> (lim == $past(wfield)));

endmodule

// File: rtl/tmr_count.sv
// Module: tmr_count
// Up-counter in units, wrap on reaching the limit, sticky reached flag and irq.
// Priority: restart beats tick; a reach event beats an acknowledge.
module tmr_count #(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             ack_rd,
    input  logic [CNT_W-1:0] lim,
    output logic [CNT_W-1:0] cnt,
    output logic             reached,
    output logic             irq
);

    logic [CNT_W:0] nxt;
    logic           hit;

    // Next count and reach detection (at or above the limit wraps)
    always_comb begin
        nxt = {1'b0, cnt} + 1'b1;
        hit = tick && !restart && (nxt >= {1'b0, lim});
    end

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart)
            cnt <= '0;
        else if (tick)
            cnt <= hit ? '0 : nxt[CNT_W-1:0];
    end

    // Sticky reached flag, cleared only by an acknowledging read
    always_ff @(posedge clk) begin
        if (!rst_n)
            reached <= 1'b0;
        else if (hit)
            reached <= 1'b1;
        else if (ack_rd)
            reached <= 1'b0;
    end

    // Interrupt level, cleared by an acknowledge or a restart
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (hit)
            irq <= 1'b1;
        else if (ack_rd || restart)
            irq <= 1'b0;
    end

    // R2: a plain tick moves the count by exactly one unit
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && !hit) |=> (cnt == $past(cnt) + 1'b1));

    // R2: without tick or restart the count holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(cnt));

    // R3: a reach event wraps and raises both flags
    a_r3_wrap_flags: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cnt == '0 && reached && irq));

    // R4: restart zeroes the count and lowers irq
    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0 && !irq));

    // R7: acknowledge without a coincident event clears both
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !hit) |=> (!reached && !irq));

    // R3: irq only rises together with the reached flag
    a_r3_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> reached);

endmodule

// File: rtl/limit_timer.sv
// Module: limit_timer (top)
// Register-mapped periodic counter-timer. Word 0: limit with restart and
// acknowledge-on-read; word 1: {reached, count}; word 2: limit, count kept.
// Assumes single-cycle strobes; rdata is combinational from addr.
module limit_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int LOW_BITS = 9,
    parameter int ADDR_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    localparam int CNT_W  = DATA_W - 1 - LOW_BITS;
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    ctl_t              ctl;
    logic [CNT_W-1:0]  lim;
    logic [CNT_W-1:0]  cnt;
    logic              reached;
    logic              unused_bits;

    assign word        = addr[ADDR_W-1:2];
    assign unused_bits = &{1'b0, addr[1:0], wdata[LOW_BITS-1:0], wdata[DATA_W-1]};

    tmr_decode #(.WORD_W(WORD_W)) u_dec (
        .wr_en (wr_en),
        .rd_en (rd_en),
        .word  (word),
        .ctl   (ctl)
    );

    tmr_limit #(.CNT_W(CNT_W)) u_lim (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (ctl.lim_wr),
        .wfield (wdata[DATA_W-2:LOW_BITS]),
        .lim    (lim)
    );

    tmr_count #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .restart (ctl.restart),
        .ack_rd  (ctl.ack_rd),
        .lim     (lim),
        .cnt     (cnt),
        .reached (reached),
        .irq     (irq)
    );

    // Read multiplexer; unmapped words return zero
    always_comb begin
        rdata = '0;
        if (word == WORD_W'(W_LIMRST))
            rdata = {1'b0, lim, {LOW_BITS{1'b0}}};
        else if (word == WORD_W'(W_COUNT))
            rdata = {reached, cnt, {LOW_BITS{1'b0}}};
    end

    // R9: writes to unmapped words or the count word leave the limit alone
    a_r9_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word != WORD_W'(W_LIMRST) && word != WORD_W'(W_LIMKEEP))
        |=> $stable(lim));

    // R8: a count read with no tick or restart leaves the count unchanged
    a_r8_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && word == WORD_W'(W_COUNT) && !tick_en && !ctl.restart)
        |=> $stable(cnt));

endmodule

// File: tb/sim_limit_timer.sv
`timescale 1ns/1ps
// Bench: behavioural model of limit, count, reached and irq, compared every clock.
module sim_limit_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state in count units
    int m_lim, m_cnt;
    bit m_reached, m_irq;

    always #4 clk = ~clk;

    limit_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input int w);
        logic [31:0] v;
        v = '0;
        if (w == 0) v = 32'(m_lim) << 9;
        else if (w == 1) v = {m_reached, 31'(m_cnt) << 9};
        return v;
    endfunction

    // one clock: drive, compare pre-edge outputs, step the model at the edge
    task automatic cyc(input string tag, input bit tk, input bit wr, input bit rd,
                       input int w, input logic [31:0] wd);
        int  lf;
        bit  rs, hit;
        @(negedge clk);
        tick_en = tk; wr_en = wr; rd_en = rd;
        addr = 5'(w << 2) | 5'($urandom_range(0, 3)); wdata = wd;
        #1;
        check({tag, " rdata"}, rdata, model_read(w));
        check({tag, " irq"}, {31'b0, irq}, {31'b0, m_irq});
        @(posedge clk);
        rs  = wr && (w == 0);
        hit = tk && !rs && (m_cnt + 1 >= m_lim);
        if (rs) m_cnt = 0;
        else if (tk) m_cnt = hit ? 0 : m_cnt + 1;
        if (hit) m_reached = 1;
        else if (rd && w == 0) m_reached = 0;
        if (hit) m_irq = 1;
        else if ((rd && w == 0) || rs) m_irq = 0;
        if (wr && (w == 0 || w == 2)) begin
            lf = int'((wd >> 9) & 32'h003F_FFFF);
            m_lim = (lf == 0) ? 32'h003F_FFFF : lf;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_en = 0; wr_en = 0; rd_en = 0;
        repeat (3) @(posedge clk);
        m_lim = 32'h003F_FFFF; m_cnt = 0; m_reached = 0; m_irq = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        do_reset();
        // R1: reset defaults, checked against fixed values as well
        @(negedge clk); addr = 5'h00; #1 check("R1 limit", rdata, 32'h7FFF_FE00);
        addr = 5'h04; #1 check("R1 count", rdata, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        // R2: counting and holding
        for (int i = 0; i < 4; i++) cyc("R2", 1, 0, 0, 1, 0);
        for (int i = 0; i < 3; i++) cyc("R2", 0, 0, 0, 1, 0);
        @(negedge clk); addr = 5'h04; #1 check("R2 four ticks", rdata, 32'h0000_0800);
        // R4: restart with stray bits, tick in the same cycle ignored
        cyc("R4", 1, 1, 0, 0, 32'h8000_0BFF);
        cyc("R4", 0, 0, 0, 0, 0);
        // R3: five-unit period, run through two wraps
        for (int i = 0; i < 12; i++) cyc("R3", 1, 0, 0, 1, 0);
        // R8: count reads do not clear
        cyc("R8", 0, 0, 1, 1, 0);
        cyc("R8", 0, 0, 1, 1, 0);
        // R7: acknowledge clears
        cyc("R7", 0, 0, 1, 0, 0);
        cyc("R7", 0, 0, 0, 1, 0);
        // R7: acknowledge coinciding with a reach event
        cyc("R7", 0, 1, 0, 0, 32'h0000_0600);
        cyc("R7", 1, 0, 0, 1, 0);
        cyc("R7", 1, 0, 0, 1, 0);
        cyc("R7", 1, 0, 1, 0, 0);
        cyc("R7", 0, 0, 0, 1, 0);
        cyc("R7", 0, 0, 1, 0, 0);
        // R5: zero limit through both limit words
        cyc("R5", 0, 1, 0, 0, 32'h0000_01FF);
        cyc("R5", 0, 0, 1, 0, 0);
        cyc("R5", 0, 1, 0, 2, 32'h0);
        cyc("R5", 0, 0, 1, 0, 0);
        // R6: limit update without restart, with a tick in that cycle
        for (int i = 0; i < 3; i++) cyc("R6", 1, 0, 0, 1, 0);
        cyc("R6", 1, 1, 0, 2, 32'h0000_1000);
        for (int i = 0; i < 6; i++) cyc("R6", 1, 0, 0, 1, 0);
        // R10: lower the limit beneath the running count
        cyc("R10", 0, 1, 0, 2, 32'h0000_0400);
        cyc("R10", 1, 0, 0, 1, 0);
        cyc("R10", 0, 0, 0, 1, 0);
        // R9: ignored writes and zero reads
        for (int w = 3; w < 8; w++) cyc("R9", 0, 1, 0, w, 32'hFFFF_FFFF);
        cyc("R9", 0, 1, 0, 1, 32'h0000_0200);
        for (int w = 3; w < 8; w++) cyc("R9", 0, 0, 1, w, 0);
        cyc("R9", 0, 0, 0, 0, 0);
        cyc("R9", 0, 0, 0, 1, 0);
        // R1: reset in the middle of activity
        do_reset();
        cyc("R1", 0, 0, 0, 0, 0);
        cyc("R1", 0, 0, 0, 1, 0);
        // R3: random mixture with short limits
        for (int i = 0; i < 3000; i++) begin
            int w;
            w = $urandom_range(0, 7);
            if ($urandom_range(0, 9) == 0)
                cyc("R3", 1'($urandom), 1, 0, w, 32'($urandom_range(0, 7)) << 9);
            else
                cyc("R3", 1'($urandom_range(0, 3) != 0), 0,
                    1'($urandom_range(0, 5) == 0), w, 0);
        end
        finish_run();
    end

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

endmodule